// File: doc/BRIEF.md
# Disk Address Range Check and Byte Offset Unit

This unit turns a cylinder/head/sector request into the byte position of that sector inside a flat disk image. It keeps the geometry of the attached drive in a small register set: cylinder count, heads, sectors per track and a sector-size code. A start pulse with a request first compares the request against that geometry. A request outside the geometry finishes at once with an error. A request inside it runs a short serial multiply that yields the linear sector number, which a final shift by the sector size turns into a byte offset.

The geometry is written through a one-cycle configuration strobe. A write that breaks any limit is dropped whole, so the geometry in use is always legal. The geometry is also locked while a calculation is running. After reset the unit holds a 512-cylinder, 4-head, 16-sector, 512-byte geometry.

Top module: `chs_locator`

## Requirements
- R1: After reset the geometry is 512 cylinders, 4 heads, 16 sectors per track and 512-byte sectors.
- R2: A start in idle whose cylinder is not below the cylinder count, or whose head is not below the head count, or whose sector is not below the sectors per track, gives `done` and `err` together one cycle after the start, and leaves `offset` unchanged.
- R3: A start in idle with an in-range request gives `done` with `err` low 1 + HEAD_W + SPT_W cycles after the start (14 with defaults). `offset` is then ((cyl × heads + head) × spt + sector) × sector size.
- R4: The size code on `cfg_size` selects the sector size: 0 means 128 bytes, 1 means 256 and 2 means 512.
- R5: A configuration write is applied whole only if cylinders lie in 1..1024, heads in 1..8, sectors per track in 1..256 and the size code is not 3. Otherwise all previous geometry values are kept.
- R6: A start while a calculation is running is ignored. The running result is unchanged and no extra `done` follows.
- R7: `busy` is high from the cycle after an accepted in-range start until the result cycle, and is low with `done`.
- R8: A configuration write while `busy` is high is ignored and has no effect on the result or on later requests.
- R9: `done` is a single-cycle pulse per accepted start, and `err` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Geometry write strobe |
| cfg_cyls | input | CYL_W (11) | Cylinder count to load |
| cfg_heads | input | HEAD_W (4) | Head count to load |
| cfg_spt | input | SPT_W (9) | Sectors per track to load |
| cfg_size | input | 2 | Sector size code: 0=128, 1=256, 2=512 |
| start | input | 1 | Request strobe |
| req_cyl | input | CYL_W (11) | Requested cylinder |
| req_head | input | HEAD_W (4) | Requested head |
| req_sect | input | SPT_W (9) | Requested sector |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | Result pulse |
| err | output | 1 | Request out of range, valid with done |
| offset | output | OFF_W (30) | Byte offset of the sector, valid with done and err low |

## Verification
A corrupted geometry register would show up on the first request after the fault. The result would then carry a wrong offset or a wrong error decision, 1 or 14 cycles after the start. A slip in the multiply counter or shift registers shows up as a wrong offset or a wrong `done` latency on the same request. Random geometries and addresses make those paths visible across many head and sector-per-track bit patterns. A lost or stuck state bit shows up as `busy` failing to fall, an extra `done`, or a second start altering a running result.

// File: rtl/chs_locator.sv
module chs_locator #(
  parameter int MAX_CYL  = 1024,
  parameter int MAX_HEAD = 8,
  parameter int MAX_SPT  = 256,
  parameter int DEF_CYL  = 512,
  parameter int DEF_HEAD = 4,
  parameter int DEF_SPT  = 16,
  parameter int DEF_SIZE = 2,
  localparam int CYL_W  = $clog2(MAX_CYL + 1),
  localparam int HEAD_W = $clog2(MAX_HEAD + 1),
  localparam int SPT_W  = $clog2(MAX_SPT + 1),
  localparam int IDX_W  = $clog2(MAX_CYL * MAX_HEAD * MAX_SPT),
  localparam int OFF_W  = IDX_W + 9,
  localparam int CNT_W  = $clog2(SPT_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CYL_W-1:0]  cfg_cyls,
  input  logic [HEAD_W-1:0] cfg_heads,
  input  logic [SPT_W-1:0]  cfg_spt,
  input  logic [1:0]        cfg_size,
  input  logic              start,
  input  logic [CYL_W-1:0]  req_cyl,
  input  logic [HEAD_W-1:0] req_head,
  input  logic [SPT_W-1:0]  req_sect,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [OFF_W-1:0]  offset
);
  typedef enum logic [1:0] {S_IDLE, S_MUL_H, S_MUL_S} st_t;
  st_t st;

  logic [CYL_W-1:0]  g_cyls;
  logic [HEAD_W-1:0] g_heads;
  logic [SPT_W-1:0]  g_spt;
  logic [1:0]        g_size;

  logic [IDX_W-1:0]  acc, mcand;
  logic [SPT_W-1:0]  mplr;
  logic [CNT_W-1:0]  cnt;
  logic [HEAD_W-1:0] r_head;
  logic [SPT_W-1:0]  r_sect;

  assign busy = (st != S_IDLE);

  wire cfg_ok = (cfg_cyls != '0) && (cfg_cyls <= CYL_W'(MAX_CYL)) &&
                (cfg_heads != '0) && (cfg_heads <= HEAD_W'(MAX_HEAD)) &&
                (cfg_spt != '0) && (cfg_spt <= SPT_W'(MAX_SPT)) &&
                (cfg_size != 2'd3);

  wire in_range = (req_cyl < g_cyls) && (req_head < g_heads) && (req_sect < g_spt);

  wire [IDX_W-1:0] acc_nxt = acc + (mplr[0] ? mcand : '0);
  wire [IDX_W-1:0] idx_fin = acc_nxt + IDX_W'(r_sect);
  wire [OFF_W-1:0] idx_ext = OFF_W'(idx_fin);

  logic [OFF_W-1:0] scaled;
  always_comb begin
    case (g_size)
      2'd0:    scaled = idx_ext << 7;
      2'd1:    scaled = idx_ext << 8;
      default: scaled = idx_ext << 9;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_cyls  <= CYL_W'(DEF_CYL);
      g_heads <= HEAD_W'(DEF_HEAD);
      g_spt   <= SPT_W'(DEF_SPT);
      g_size  <= 2'(DEF_SIZE);
    end else if (cfg_we && !busy && cfg_ok) begin
      g_cyls  <= cfg_cyls;
      g_heads <= cfg_heads;
      g_spt   <= cfg_spt;
      g_size  <= cfg_size;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      err    <= 1'b0;
      offset <= '0;
      acc    <= '0;
      mcand  <= '0;
      mplr   <= '0;
      cnt    <= '0;
      r_head <= '0;
      r_sect <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (!in_range) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            acc    <= '0;
            mcand  <= IDX_W'(req_cyl);
            mplr   <= SPT_W'(g_heads);
            cnt    <= CNT_W'(HEAD_W);
            r_head <= req_head;
            r_sect <= req_sect;
            st     <= S_MUL_H;
          end
        end
        S_MUL_H: begin
          if (cnt == CNT_W'(1)) begin
            mcand <= acc_nxt + IDX_W'(r_head);
            acc   <= '0;
            mplr  <= g_spt;
            cnt   <= CNT_W'(SPT_W);
            st    <= S_MUL_S;
          end else begin
            acc   <= acc_nxt;
            mcand <= mcand << 1;
            mplr  <= mplr >> 1;
            cnt   <= cnt - 1'b1;
          end
        end
        S_MUL_S: begin
          if (cnt == CNT_W'(1)) begin
            offset <= scaled;
            done   <= 1'b1;
            st     <= S_IDLE;
          end else begin
            acc   <= acc_nxt;
            mcand <= mcand << 1;
            mplr  <= mplr >> 1;
            cnt   <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chs_locator_chk.sv
module chs_locator_chk #(
  parameter int MAX_CYL = 1024,
  parameter int MAX_HEAD = 8,
  parameter int MAX_SPT = 256,
  parameter int CYL_W = 11,
  parameter int HEAD_W = 4,
  parameter int SPT_W = 9,
  parameter int OFF_W = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [OFF_W-1:0]  offset,
  input logic [CYL_W-1:0]  req_cyl,
  input logic [HEAD_W-1:0] req_head,
  input logic [SPT_W-1:0]  req_sect,
  input logic [CYL_W-1:0]  g_cyls,
  input logic [HEAD_W-1:0] g_heads,
  input logic [SPT_W-1:0]  g_spt,
  input logic [1:0]        g_size
);
  wire bad_req = (req_cyl >= g_cyls) || (req_head >= g_heads) || (req_sect >= g_spt);

  p_bad_req_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && bad_req |=> done && err && $stable(offset));

  p_good_req_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !bad_req |=> busy && !done);

  p_busy_ends_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || done);

  p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_err_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_geom_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (g_cyls != '0) && (g_cyls <= CYL_W'(MAX_CYL)) && (g_heads != '0) &&
    (g_heads <= HEAD_W'(MAX_HEAD)) && (g_spt != '0) && (g_spt <= SPT_W'(MAX_SPT)) &&
    (g_size != 2'd3));

  p_geom_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(g_cyls) && $stable(g_heads) && $stable(g_spt) && $stable(g_size));

  p_offset_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> offset[6:0] == 7'd0);
endmodule

bind chs_locator chs_locator_chk #(
  .MAX_CYL(MAX_CYL), .MAX_HEAD(MAX_HEAD), .MAX_SPT(MAX_SPT),
  .CYL_W(CYL_W), .HEAD_W(HEAD_W), .SPT_W(SPT_W), .OFF_W(OFF_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .offset(offset), .req_cyl(req_cyl), .req_head(req_head), .req_sect(req_sect),
  .g_cyls(g_cyls), .g_heads(g_heads), .g_spt(g_spt), .g_size(g_size)
);

// File: tb/chs_locator_tb_top.sv
module chs_locator_tb_top;
  localparam int CYL_W = 11, HEAD_W = 4, SPT_W = 9, OFF_W = 30;
  localparam int LAT_OK = 1 + HEAD_W + SPT_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, start = 1'b0;
  logic [CYL_W-1:0] cfg_cyls = '0, req_cyl = '0;
  logic [HEAD_W-1:0] cfg_heads = '0, req_head = '0;
  logic [SPT_W-1:0] cfg_spt = '0, req_sect = '0;
  logic [1:0] cfg_size = '0;
  logic busy, done, err;
  logic [OFF_W-1:0] offset;

  int checks = 0, errors = 0, cyc = 0;
  int m_cyl = 512, m_head = 4, m_spt = 16, m_size = 2;

  always #10 clk = ~clk;

  chs_locator dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cyls(cfg_cyls),
    .cfg_heads(cfg_heads), .cfg_spt(cfg_spt), .cfg_size(cfg_size),
    .start(start), .req_cyl(req_cyl), .req_head(req_head), .req_sect(req_sect),
    .busy(busy), .done(done), .err(err), .offset(offset)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycle %0d expected under 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_off(int c, int h, int s);
    return (longint'((c * m_head + h) * m_spt + s)) << (7 + m_size);
  endfunction

  function automatic bit legal(int c, int h, int s, int z);
    return c >= 1 && c <= 1024 && h >= 1 && h <= 8 && s >= 1 && s <= 256 && z != 3;
  endfunction

  task automatic cfg(int c, int h, int s, int z);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cyls = CYL_W'(c); cfg_heads = HEAD_W'(h);
    cfg_spt = SPT_W'(s); cfg_size = 2'(z);
    @(negedge clk);
    cfg_we = 1'b0;
    if (legal(c, h, s, z)) begin m_cyl = c; m_head = h; m_spt = s; m_size = z; end
  endtask

  task automatic calc(int c, int h, int s, string tag);
    longint prev = longint'(offset);
    bit bad = (c >= m_cyl) || (h >= m_head) || (s >= m_spt);
    int lat = 0;
    @(negedge clk);
    start = 1'b1; req_cyl = CYL_W'(c); req_head = HEAD_W'(h); req_sect = SPT_W'(s);
    do begin
      @(posedge clk); #1; start = 1'b0; lat++;
    end while (!done && lat < 40);
    chk({tag, " latency"}, lat, bad ? 1 : LAT_OK);
    chk({tag, " err"}, err, bad);
    chk({tag, " offset"}, offset, bad ? prev : exp_off(c, h, s));
    @(posedge clk); #1;
    chk({tag, " done pulse R9"}, done, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    @(negedge clk); rst_n = 1'b1;

    calc(511, 3, 15, "R1 default top corner R3");
    calc(512, 0, 0, "R1 cyl limit R2");
    calc(0, 4, 0, "R2 head limit");
    calc(0, 0, 16, "R2 sector limit");
    calc(0, 0, 0, "R3 zero");

    cfg(1024, 8, 256, 0);
    calc(1023, 7, 255, "R4 max geometry 128B");
    cfg(10, 2, 5, 1);
    calc(9, 1, 4, "R4 256B");
    cfg(0, 2, 5, 2);    calc(9, 1, 4, "R5 zero cyl kept");
    cfg(1025, 2, 5, 2); calc(9, 1, 4, "R5 big cyl kept");
    cfg(20, 9, 5, 2);   calc(10, 1, 4, "R5 big head kept");
    cfg(20, 2, 257, 2); calc(9, 1, 5, "R5 big spt kept");
    cfg(20, 2, 5, 3);   calc(9, 1, 4, "R5 size 3 kept");

    // R6: second start during a run is ignored
    begin
      int npulse = 0;
      @(negedge clk);
      start = 1'b1; req_cyl = 11'd3; req_head = 4'd1; req_sect = 9'd2;
      @(negedge clk); start = 1'b0;
      chk("R7 busy after start", busy, 1);
      @(negedge clk);
      start = 1'b1; req_cyl = 11'd0; req_head = 4'd0; req_sect = 9'd0;
      // R8: geometry write while busy
      cfg_we = 1'b1; cfg_cyls = 11'd100; cfg_heads = 4'd8; cfg_spt = 9'd100; cfg_size = 2'd0;
      @(negedge clk); start = 1'b0; cfg_we = 1'b0;
      for (int i = 0; i < 30; i++) begin
        @(posedge clk); #1;
        if (done) begin
          npulse++;
          chk("R6 running result kept", offset, exp_off(3, 1, 2));
          chk("R7 busy low with done", busy, 0);
        end
      end
      chk("R6 single done", npulse, 1);
      calc(9, 1, 4, "R8 geometry unchanged");
    end

    for (int i = 0; i < 150; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        int c = $urandom_range(0, 1100), h = $urandom_range(0, 9);
        int s = $urandom_range(0, 270), z = $urandom_range(0, 3);
        cfg(c, h, s, z);
      end
      if ($urandom_range(0, 4) == 0)
        calc($urandom_range(0, 1100), $urandom_range(0, 9), $urandom_range(0, 270), "R2 random");
      else
        calc($urandom_range(0, m_cyl - 1), $urandom_range(0, m_head - 1),
             $urandom_range(0, m_spt - 1), "R3 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule